// File: doc/BRIEF.md
# Prescaled Tick Counter

This block is an 8-bit up-counter for a small microcontroller core. It counts one of three sources: instruction-cycle ticks (the system clock divided by four), edges on an external clock pin, or edges on an alternate oscillator input. Edge polarity can be selected. A single 8-bit prescaler can be placed in front of the counter, or it can be lent to a watchdog path. When it is lent to the watchdog, the counter sees every source tick undivided.

Software loads the count through a write port. A write clears the prescaler and flushes the internal synchronisation pipe. As a result, the two instruction cycles that follow any load produce no increment. Each time the count wraps from 0xFF to 0x00 it sets a sticky interrupt flag, which software clears. The wrap also emits a one-clock pulse that a neighbouring timer can use as a gate. The watchdog side divides its own tick input by 512 and then, optionally, by the prescaler, and reports each expiry as a one-clock pulse.

Top module: `prescaled_tick_counter`

## Requirements
- R1: After reset, count is 0x00, and ovf_flag, ovf_pulse and wdog_expire are 0.
- R2: With sel_ext=0 and the prescaler lent to the watchdog (pre_to_wdog=1), the count rises by exactly one per instruction cycle, which is every 4 clocks in steady state.
- R3: With sel_ext=1, sel_alt=0 counts edges on ext_pin and sel_alt=1 counts edges on alt_osc. Toggling the unselected input leaves the count unchanged.
- R4: With sel_ext=1, edge_fall=0 counts low-to-high transitions and edge_fall=1 counts high-to-low transitions of the selected input.
- R5: With pre_to_wdog=0, the counter advances once per 2^(pre_ratio+1) source ticks (pre_ratio is 3 bits, so 1:2 up to 1:256). A write clears the prescaler, so N source ticks after a load give floor(N / 2^(pre_ratio+1)) increments.
- R6: A clock with wr_en=1 loads wr_data into count on that edge. The write overrides any increment due on the same edge.
- R7: After a load, count holds its value for the next 8 clocks (two instruction cycles). In timer mode without prescaling, it reads load+1 exactly 12 clocks after the load edge.
- R8: A wrap from 0xFF to 0x00 sets ovf_flag and raises ovf_pulse for one clock. ovf_flag stays set until flag_clr is asserted, and a new wrap wins over flag_clr on the same edge.
- R9: With pre_to_wdog=0, wdog_expire pulses once per 512 wdog_tick pulses. With pre_to_wdog=1, it pulses once per 512 * 2^(pre_ratio+1) wdog_tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 8 | Value to load |
| sel_ext | input | 1 | 0: instruction ticks, 1: external edges |
| sel_alt | input | 1 | Edge source: 0 ext_pin, 1 alt_osc |
| edge_fall | input | 1 | 0: rising edges, 1: falling edges |
| pre_to_wdog | input | 1 | 1: prescaler serves the watchdog path |
| pre_ratio | input | 3 | Prescaler ratio select |
| ext_pin | input | 1 | External clock pin (asynchronous) |
| alt_osc | input | 1 | Alternate oscillator input (asynchronous) |
| wdog_tick | input | 1 | Watchdog oscillator tick, one clock wide |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-clock pulse on each wrap |
| wdog_expire | output | 1 | One-clock watchdog expiry pulse |

## Verification
A software load and a counting increment can land on the same clock edge. The load must win, and it must also restart the two-cycle hold-off. The bench provokes this by running the timer at full rate and issuing loads at each of the four clock phases of an instruction cycle, plus random phases. After each load it checks that the written value appears on the next clock, stays fixed for eight clocks, and reads one higher at the twelfth.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

   typedef enum logic [1:0] {
      SRC_CYC = 2'd0,
      SRC_PIN = 2'd1,
      SRC_ALT = 2'd2
   } src_e;

   function automatic src_e pick_src(input logic ext, input logic alt);
      if (!ext)     return SRC_CYC;
      else if (alt) return SRC_ALT;
      else          return SRC_PIN;
   endfunction

endpackage

// File: rtl/ptc_edge_sync.sv
module ptc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_a,
   input  logic pin_b,
   input  logic use_b,
   input  logic on_fall,
   output logic edge_pulse
);
   localparam int LANES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("ptc_edge_sync: STAGES must be at least 2");
   end

   logic [LANES-1:0] raw;
   logic [LANES-1:0] synced;
   logic             level, level_q;

   assign raw = {pin_b, pin_a};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign synced[l] = chain[STAGES-1];
   end

   assign level = use_b ? synced[1] : synced[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign edge_pulse = on_fall ? (level_q & ~level) : (~level_q & level);

endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
   parameter int PRE_W      = 8,
   parameter int RATIO_W    = 3,
   parameter int WDOG_DIV_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               to_wdog,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               cnt_tick,
   input  logic               wdog_tick,
   output logic               cnt_out,
   output logic               wdog_expire
);
   if (PRE_W < (1 << RATIO_W)) begin : g_bad_width
      $error("ptc_prescaler: PRE_W too narrow for RATIO_W");
   end

   logic [PRE_W-1:0] pre_cnt, mask;
   logic             wdiv_carry, pre_in, pre_hit;

   if (WDOG_DIV_W == 0) begin : g_no_wdiv
      assign wdiv_carry = wdog_tick;
   end else begin : g_wdiv
      logic [WDOG_DIV_W-1:0] wdiv;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         wdiv <= '0;
         else if (wdog_tick) wdiv <= wdiv + 1'b1;
      end
      assign wdiv_carry = wdog_tick && (wdiv == '1);
   end

   always_comb begin
      for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(ratio));
   end

   assign pre_in  = to_wdog ? wdiv_carry : cnt_tick;
   assign pre_hit = pre_in && ((pre_cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_cnt <= '0;
      else if (clr)    pre_cnt <= '0;
      else if (pre_in) pre_cnt <= pre_cnt + 1'b1;
   end

   assign cnt_out = to_wdog ? cnt_tick : pre_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdog_expire <= 1'b0;
      else        wdog_expire <= to_wdog ? pre_hit : wdiv_carry;
   end

   // R5
   cnt_from_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_out |-> cnt_tick);

   // R9
   expire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_expire |-> $past(wdog_tick));

endmodule

// File: rtl/ptc_core.sv
module ptc_core #(
   parameter int CNT_W       = 8,
   parameter int SYNC_CYCLES = 2,
   parameter int CYC_DIV     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_tick,
   input  logic             tick_in,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             ovf_pulse
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam int HOLD_CLKS = SYNC_CYCLES * CYC_DIV;
   localparam int AGE_W     = $clog2(HOLD_CLKS + 1) + 1;

   if (SYNC_CYCLES < 2) begin : g_bad_sync
      $error("ptc_core: SYNC_CYCLES must be at least 2");
   end

   logic                   hold;
   logic [SYNC_CYCLES-1:0] pipe;
   logic                   step, wrap;

   assign step = cyc_tick && pipe[SYNC_CYCLES-1];
   assign wrap = !wr_en && step && (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         hold  <= 1'b0;
         pipe  <= '0;
      end else if (wr_en) begin
         count <= wr_data;
         hold  <= 1'b0;
         pipe  <= '0;
      end else begin
         if (cyc_tick) begin
            pipe <= {pipe[SYNC_CYCLES-2:0], hold | tick_in};
            hold <= 1'b0;
         end else if (tick_in) begin
            hold <= 1'b1;
         end
         if (step) count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag  <= 1'b0;
         ovf_pulse <= 1'b0;
      end else begin
         ovf_pulse <= wrap;
         if (wrap)          ovf_flag <= 1'b1;
         else if (flag_clr) ovf_flag <= 1'b0;
      end
   end

   logic [AGE_W-1:0] wr_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            wr_age <= '1;
      else if (wr_en)                        wr_age <= '0;
      else if (wr_age != '1)                 wr_age <= wr_age + 1'b1;
   end

   // R6
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> count == $past(wr_data));

   // R7
   write_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && int'(wr_age) < HOLD_CLKS) |=> count == $past(count));

   // R2
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

   // R8
   wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (count == '0) && ovf_flag && ($past(count) == CNT_MAX));

   // R8
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ovf_pulse);

endmodule

// File: rtl/prescaled_tick_counter.sv
module prescaled_tick_counter #(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 8,
   parameter int RATIO_W     = 3,
   parameter int CYC_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SYNC_CYCLES = 2,
   parameter int WDOG_DIV_W  = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic               sel_ext,
   input  logic               sel_alt,
   input  logic               edge_fall,
   input  logic               pre_to_wdog,
   input  logic [RATIO_W-1:0] pre_ratio,
   input  logic               ext_pin,
   input  logic               alt_osc,
   input  logic               wdog_tick,
   input  logic               flag_clr,
   output logic [CNT_W-1:0]   count,
   output logic               ovf_flag,
   output logic               ovf_pulse,
   output logic               wdog_expire
);
   import ptc_pkg::*;

   localparam int PH_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

   if (CYC_DIV < 2) begin : g_bad_div
      $error("prescaled_tick_counter: CYC_DIV must be at least 2");
   end

   logic [PH_W-1:0] phase;
   logic            cyc_tick, ext_edge, raw_tick, pre_tick;
   src_e            src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase <= '0;
      else if (cyc_tick) phase <= '0;
      else               phase <= phase + 1'b1;
   end
   assign cyc_tick = (phase == PH_W'(CYC_DIV - 1));

   assign src = pick_src(sel_ext, sel_alt);

   ptc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_a      (ext_pin),
      .pin_b      (alt_osc),
      .use_b      (src == SRC_ALT),
      .on_fall    (edge_fall),
      .edge_pulse (ext_edge)
   );

   assign raw_tick = (src == SRC_CYC) ? cyc_tick : ext_edge;

   ptc_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_W), .WDOG_DIV_W(WDOG_DIV_W)) u_pre (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (wr_en),
      .to_wdog     (pre_to_wdog),
      .ratio       (pre_ratio),
      .cnt_tick    (raw_tick),
      .wdog_tick   (wdog_tick),
      .cnt_out     (pre_tick),
      .wdog_expire (wdog_expire)
   );

   ptc_core #(.CNT_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES), .CYC_DIV(CYC_DIV)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_tick  (cyc_tick),
      .tick_in   (pre_tick),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .flag_clr  (flag_clr),
      .count     (count),
      .ovf_flag  (ovf_flag),
      .ovf_pulse (ovf_pulse)
   );

endmodule

// File: tb/tb_prescaled_tick_counter.sv
`timescale 1ns/1ps
module tb_prescaled_tick_counter;
   logic       clk = 1'b0;
   logic       rst_n, wr_en, sel_ext, sel_alt, edge_fall, pre_to_wdog;
   logic       ext_pin, alt_osc, wdog_tick, flag_clr;
   logic [7:0] wr_data;
   logic [2:0] pre_ratio;
   logic [7:0] count;
   logic       ovf_flag, ovf_pulse, wdog_expire;

   int checks = 0, errors = 0, ovf_seen = 0, exp_seen = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   prescaled_tick_counter dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sel_ext(sel_ext), .sel_alt(sel_alt), .edge_fall(edge_fall),
      .pre_to_wdog(pre_to_wdog), .pre_ratio(pre_ratio),
      .ext_pin(ext_pin), .alt_osc(alt_osc), .wdog_tick(wdog_tick),
      .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag),
      .ovf_pulse(ovf_pulse), .wdog_expire(wdog_expire)
   );

   always @(negedge clk) begin
      if (rst_n && ovf_pulse)   ovf_seen++;
      if (rst_n && wdog_expire) exp_seen++;
   end

   function automatic int div_of(input bit to_wd, input int r);
      return to_wd ? 1 : (1 << (r + 1));
   endfunction

   function automatic logic [7:0] after_ticks(input logic [7:0] w, input int n, input int d);
      return 8'(int'(w) + n / d);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic configure(input bit ext, input bit alt, input bit fall, input bit to_wd, input int r);
      @(negedge clk);
      sel_ext = ext; sel_alt = alt; edge_fall = fall; pre_to_wdog = to_wd; pre_ratio = 3'(r);
      ext_pin = 1'b0; alt_osc = 1'b0;
      clocks(6);
   endtask

   task automatic pulses(input bit on_alt, input bit noise, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (on_alt) alt_osc = 1'b1; else ext_pin = 1'b1;
         if (noise) begin if (on_alt) ext_pin = 1'b1; else alt_osc = 1'b1; end
         clocks(6);
         ext_pin = 1'b0; alt_osc = 1'b0;
         clocks(6);
      end
      clocks(24);
   endtask

   task automatic wd_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wdog_tick = 1'b1;
         @(negedge clk); wdog_tick = 1'b0;
      end
      clocks(3);
   endtask

   task automatic load_and_watch(input logic [7:0] v);
      int bad = 0;
      load(v);
      // R6: value visible one clock after the load edge
      chk("R6 load value", int'(count), int'(v));
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (count != v) bad++;
      end
      // R7: no increment in the eight clocks after a load
      chk("R7 hold-off stable", bad, 0);
      clocks(4);
      // R7: first increment lands exactly by the twelfth clock
      chk("R7 first step", int'(count), int'(8'(v + 8'd1)));
   endtask

   initial begin
      logic [7:0] w, c0;
      int r, m, n, d;
      bit alt, fall, to_wd, noise;
      void'($urandom(32'd4242));
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sel_ext = 1'b0; sel_alt = 1'b0;
      edge_fall = 1'b0; pre_to_wdog = 1'b1; pre_ratio = '0; ext_pin = 1'b0;
      alt_osc = 1'b0; wdog_tick = 1'b0; flag_clr = 1'b0;
      clocks(5);
      // R1: reset state
      chk("R1 count", int'(count), 0);
      chk("R1 flag", int'(ovf_flag), 0);
      chk("R1 pulse", int'(ovf_pulse), 0);
      chk("R1 expire", int'(wdog_expire), 0);
      rst_n = 1'b1;

      // R9: watchdog with prescaler (ratio 0 -> 1024 ticks), then without (512)
      wd_ticks(1023);
      chk("R9 no early expiry", exp_seen, 0);
      wd_ticks(1);
      chk("R9 expiry at 1024", exp_seen, 1);
      @(negedge clk); pre_to_wdog = 1'b0;
      wd_ticks(511);
      chk("R9 no early expiry direct", exp_seen, 1);
      wd_ticks(1);
      chk("R9 expiry at 512", exp_seen, 2);

      // R6 / R7: loads at every phase while timer runs at full rate
      configure(0, 0, 0, 1, 7);
      load(8'h10);
      clocks(16);
      for (int ph = 0; ph < 4; ph++) begin
         clocks(ph);
         load_and_watch(8'(8'h40 + ph * 8'h11));
         clocks(8);
      end
      for (int i = 0; i < 4; i++) begin
         clocks(int'($urandom_range(0, 7)));
         load_and_watch(8'($urandom));
      end

      // R2: full-rate timer, rate over 40 clocks
      clocks(4);
      c0 = count; clocks(40);
      chk("R2 ten steps", int'(8'(count - c0)), 10);

      // R8: wrap sets flag, one pulse, then clear
      @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      ovf_seen = 0;
      load(8'hFE);
      clocks(17);
      chk("R8 flag set", int'(ovf_flag), 1);
      chk("R8 single pulse", ovf_seen, 1);
      clocks(20);
      chk("R8 flag sticky", int'(ovf_flag), 1);
      @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      chk("R8 flag cleared", int'(ovf_flag), 0);

      // R3: unselected input ignored, selected counted
      configure(1, 0, 0, 1, 0);
      load(8'h20);
      pulses(1, 0, 5);
      chk("R3 alt ignored when pin selected", int'(count), 8'h20);
      pulses(0, 0, 3);
      chk("R3 pin counted", int'(count), 8'h23);
      configure(1, 1, 0, 1, 0);
      load(8'h30);
      pulses(0, 0, 4);
      chk("R3 pin ignored when alt selected", int'(count), 8'h30);
      pulses(1, 0, 2);
      chk("R3 alt counted", int'(count), 8'h32);

      // R4: falling edges
      configure(1, 0, 1, 1, 0);
      load(8'h50);
      pulses(0, 1, 4);
      chk("R4 falling edges", int'(count), 8'h54);

      // R5: directed prescaler ratio 1:4 with 9 edges
      configure(1, 0, 0, 0, 1);
      load(8'h00);
      pulses(0, 0, 9);
      chk("R5 ratio 1:4", int'(count), 2);

      // R5 timer with prescaler ratios
      for (int rr = 0; rr < 3; rr++) begin
         configure(0, 0, 0, 0, rr);
         load(8'h00);
         d = div_of(0, rr);
         clocks(16 + 8 * d);
         c0 = count; m = 3;
         clocks(4 * d * m);
         chk("R5 timer ratio", int'(8'(count - c0)), m);
      end

      // Random mix, checked against computed expectations
      for (int it = 0; it < 16; it++) begin
         w = 8'($urandom);
         if ($urandom_range(0, 1) == 1) begin
            alt = 1'($urandom); fall = 1'($urandom); to_wd = 1'($urandom);
            noise = 1'($urandom); r = int'($urandom_range(0, 2));
            n = int'($urandom_range(1, 20));
            configure(1, alt, fall, to_wd, r);
            load(w);
            pulses(alt, noise, n);
            // R3 R4 R5: random edge counting
            chk("R5 random edges", int'(count), int'(after_ticks(w, n, div_of(to_wd, r))));
         end else begin
            to_wd = 1'($urandom); r = int'($urandom_range(0, 2));
            d = div_of(to_wd, r);
            m = int'($urandom_range(1, 4));
            configure(0, 0, 0, to_wd, r);
            load(w);
            clocks(16 + 8 * d);
            c0 = count;
            clocks(4 * d * m);
            // R2 R5: random timer rate
            chk("R2 random timer rate", int'(8'(count - c0)), m);
         end
      end

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule